// File: doc/BRIEF.md
# Dual-Multiplier Accumulate Cascade Slice

This block is a pipelined fixed-point arithmetic slice. It holds two signed multipliers, a wide one (top) and a narrow one (bottom). Either multiplier can form its second operand with a pre-adder. Either can also take its first operand from a bank of eight constant coefficients, chosen each cycle by a 3-bit select, instead of from its data input. A run-time add/subtract stage joins the two products. A chain adder then combines that sum with a 64-bit cascade input and, when asked, with the slice's own previous result and a rounding constant.

Slices are tiled into a chain. Each slice's registered result is also its cascade output, and that output feeds the cascade input of the next slice. A separate 27-bit scan path forwards the registered top first operand to the next slice, and a slice may be built to take its top first operand from that path. There are three register stages: input, pipeline and output. Each stage has its own clock enable. One synchronous clear covers the input stage, and a second covers the pipeline and output stages.

Top module: `dmac_slice`

## Requirements
- R1: With all three enables high and both clears low, the inputs present at a rising edge set `result` after the third rising edge, counting that one.
- R2: With the pre-adder built in, the top second operand is the signed sum of `a_y` and `a_z` at 28 bits, so that sum cannot overflow. The bottom second operand is the signed sum of `b_y` and `b_z`. Without the pre-adder, the second operand is `a_y` or `b_y` alone, and the z inputs have no effect on `result`.
- R3: With the coefficient bank built in, select code k (0 to 7) on `sel_a` or `sel_b` puts stored coefficient k in place of the x data operand of that multiplier.
- R4: `op_sub` low gives top product plus bottom product. `op_sub` high gives bottom product minus top product.
- R5: `op_neg` low adds the two-product sum to the chain total. `op_neg` high subtracts it. The chain total is `casc_in` plus the accumulator term.
- R6: `op_acc` high makes the accumulator term the previous `result`. `op_acc` low makes it zero.
- R7: `op_rnd` high adds 2 to the power RND_SHIFT to the result. The default RND_SHIFT is 17.
- R8: `casc_out` always equals `result`. All arithmetic is two's complement and wraps at 64 bits.
- R9: `scan_out` shows the top x operand captured by the input stage, one cycle after it is loaded. That operand comes from `a_x`, or from `scan_in` when SCAN_SEL is 1.
- R10: While an enable is low, its stage holds. `ce[0]` is the input stage, `ce[1]` the pipeline stage and `ce[2]` the output stage.
- R11: `clr[0]` zeroes the input stage and `clr[1]` zeroes the pipeline and output stages. Both clears are synchronous, active high, and override the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all stages |
| ce | input | 3 | Stage enables: 0 input, 1 pipeline, 2 output |
| clr | input | 2 | Clears: 0 input stage, 1 pipeline and output stages |
| a_x | input | 27 | Top multiplier first operand |
| a_y | input | 27 | Top multiplier second operand or pre-adder input |
| a_z | input | 26 | Top pre-adder addend |
| b_x | input | 18 | Bottom multiplier first operand |
| b_y | input | 19 | Bottom multiplier second operand or pre-adder input |
| b_z | input | 18 | Bottom pre-adder addend |
| sel_a | input | 3 | Top coefficient select |
| sel_b | input | 3 | Bottom coefficient select |
| op_sub | input | 1 | Product combine: 0 add, 1 bottom minus top |
| op_neg | input | 1 | Chain combine: 0 add sum, 1 subtract sum |
| op_acc | input | 1 | Feed back previous result |
| op_rnd | input | 1 | Add rounding constant |
| scan_in | input | 27 | Scan path from previous slice |
| scan_out | output | 27 | Scan path to next slice |
| casc_in | input | 64 | Chain input from previous slice |
| casc_out | output | 64 | Chain output to next slice |
| result | output | 64 | Registered result |

## Verification
The embedded assertions check the register rules on every cycle. Each enable must hold its stage, the clears must zero the stages they cover, and the scan register must load the selected x source. The arithmetic is shown only by the bench's scenarios. Those scenarios cover the add/subtract and negate choices, the accumulator feedback, the rounding constant, a sweep of the coefficient bank, and a pre-adder sum that overflows 27 bits. They run two differently built slices that share their inputs and are linked through the scan path. The chain input is skewed in the bench so that it meets each item at the output stage.

// File: rtl/dmac_slice.sv
`timescale 1ns/1ps
module dmac_slice #(
  parameter int AXW = 27,
  parameter int AYW = 27,
  parameter int AZW = 26,
  parameter int BXW = 18,
  parameter int BYW = 19,
  parameter int BZW = 18,
  parameter int RW = 64,
  parameter bit PRE_A = 1'b1,
  parameter bit PRE_B = 1'b1,
  parameter bit COEF_A_EN = 1'b0,
  parameter bit COEF_B_EN = 1'b0,
  parameter bit SCAN_SEL = 1'b0,
  parameter int RND_SHIFT = 17,
  parameter logic [8*AXW-1:0] COEF_A = '0,
  parameter logic [8*BXW-1:0] COEF_B = '0
) (
  input  logic          clk,
  input  logic [2:0]    ce,
  input  logic [1:0]    clr,
  input  logic [AXW-1:0] a_x,
  input  logic [AYW-1:0] a_y,
  input  logic [AZW-1:0] a_z,
  input  logic [BXW-1:0] b_x,
  input  logic [BYW-1:0] b_y,
  input  logic [BZW-1:0] b_z,
  input  logic [2:0]    sel_a,
  input  logic [2:0]    sel_b,
  input  logic          op_sub,
  input  logic          op_neg,
  input  logic          op_acc,
  input  logic          op_rnd,
  input  logic [AXW-1:0] scan_in,
  output logic [AXW-1:0] scan_out,
  input  logic [RW-1:0]  casc_in,
  output logic [RW-1:0]  casc_out,
  output logic [RW-1:0]  result
);
  localparam int BYZW = (BYW > BZW) ? BYW : BZW;
  localparam int AOPW = PRE_A ? AYW + 1 : AYW;
  localparam int BOPW = PRE_B ? BYZW + 1 : BYW;
  localparam int APW = AXW + AOPW;
  localparam int BPW = BXW + BOPW;
  localparam logic [RW-1:0] RND_VAL = {{(RW-1){1'b0}}, 1'b1} << RND_SHIFT;

  // input stage
  logic [AXW-1:0] ax_q, x_src;
  logic [AYW-1:0] ay_q;
  logic [AZW-1:0] az_q;
  logic [BXW-1:0] bx_q;
  logic [BYW-1:0] by_q;
  logic [BZW-1:0] bz_q;
  logic [2:0] sa_q, sb_q;
  logic [3:0] ctl1, ctl2;

  assign x_src = SCAN_SEL ? scan_in : a_x;

  always_ff @(posedge clk) begin
    if (clr[0]) begin
      ax_q <= '0; ay_q <= '0; az_q <= '0;
      bx_q <= '0; by_q <= '0; bz_q <= '0;
      sa_q <= '0; sb_q <= '0; ctl1 <= '0;
    end else if (ce[0]) begin
      ax_q <= x_src; ay_q <= a_y; az_q <= a_z;
      bx_q <= b_x; by_q <= b_y; bz_q <= b_z;
      sa_q <= sel_a; sb_q <= sel_b;
      ctl1 <= {op_rnd, op_acc, op_neg, op_sub};
    end
  end

  assign scan_out = ax_q;

  // operand formation
  logic signed [AXW-1:0]  ax_op;
  logic signed [AOPW-1:0] ay_op;
  logic signed [BXW-1:0]  bx_op;
  logic signed [BOPW-1:0] by_op;

  generate
    if (COEF_A_EN) begin : g_coef_a
      logic unused_sa;
      assign ax_op = COEF_A[int'(sa_q)*AXW +: AXW];
      assign unused_sa = 1'b0;
    end else begin : g_data_a
      logic unused_sa;
      assign ax_op = ax_q;
      assign unused_sa = ^sa_q;
    end
    if (COEF_B_EN) begin : g_coef_b
      logic unused_bx;
      assign bx_op = COEF_B[int'(sb_q)*BXW +: BXW];
      assign unused_bx = ^bx_q;
    end else begin : g_data_b
      logic unused_sb;
      assign bx_op = bx_q;
      assign unused_sb = ^sb_q;
    end
    if (PRE_A) begin : g_pre_a
      assign ay_op = $signed({ay_q[AYW-1], ay_q})
                   + $signed({{(AOPW-AZW){az_q[AZW-1]}}, az_q});
    end else begin : g_nopre_a
      logic unused_az;
      assign ay_op = ay_q;
      assign unused_az = ^az_q;
    end
    if (PRE_B) begin : g_pre_b
      assign by_op = $signed({{(BOPW-BYW){by_q[BYW-1]}}, by_q})
                   + $signed({{(BOPW-BZW){bz_q[BZW-1]}}, bz_q});
    end else begin : g_nopre_b
      logic unused_bz;
      assign by_op = by_q;
      assign unused_bz = ^bz_q;
    end
  endgenerate

  // pipeline stage: products
  logic signed [APW-1:0] pa_d, pa_q;
  logic signed [BPW-1:0] pb_d, pb_q;
  assign pa_d = ax_op * ay_op;
  assign pb_d = bx_op * by_op;

  always_ff @(posedge clk) begin
    if (clr[1]) begin
      pa_q <= '0; pb_q <= '0; ctl2 <= '0;
    end else if (ce[1]) begin
      pa_q <= pa_d; pb_q <= pb_d; ctl2 <= ctl1;
    end
  end

  // output stage: combine, chain, accumulate, round
  logic [RW-1:0] pa_x, pb_x, psum, acc_t, base, tot, res_q;
  assign pa_x  = {{(RW-APW){pa_q[APW-1]}}, pa_q};
  assign pb_x  = {{(RW-BPW){pb_q[BPW-1]}}, pb_q};
  assign psum  = ctl2[0] ? pb_x - pa_x : pa_x + pb_x;
  assign acc_t = ctl2[2] ? res_q : '0;
  assign base  = casc_in + acc_t;
  assign tot   = (ctl2[1] ? base - psum : base + psum) + (ctl2[3] ? RND_VAL : '0);

  always_ff @(posedge clk) begin
    if (clr[1]) res_q <= '0;
    else if (ce[2]) res_q <= tot;
  end

  assign result   = res_q;
  assign casc_out = res_q;

  // R9: scan register loads the selected x source
  p_scan_load_r9: assert property (@(posedge clk) disable iff (&clr)
    (ce[0] && !clr[0]) |=> scan_out == $past(x_src));
  // R10: disabled stages hold
  p_hold_in_r10: assert property (@(posedge clk) disable iff (&clr)
    (!ce[0] && !clr[0]) |=> $stable(scan_out));
  p_hold_out_r10: assert property (@(posedge clk) disable iff (&clr)
    (!ce[2] && !clr[1]) |=> $stable(result));
  // R11: clears win over enables
  p_clear_out_r11: assert property (@(posedge clk) disable iff (&clr)
    clr[1] |=> result == '0);
  p_clear_in_r11: assert property (@(posedge clk) disable iff (&clr)
    clr[0] |=> scan_out == '0);
endmodule

// File: tb/dmac_slice_tb_top.sv
`timescale 1ns/1ps
module dmac_slice_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic signed [26:0] cfa(int k);
    return 27'(k * 91573 - 300000);
  endfunction
  function automatic logic signed [17:0] cfb(int k);
    return 18'(k * 17001 - 60000);
  endfunction
  function automatic logic [8*27-1:0] pack_a();
    logic [8*27-1:0] r;
    for (int k = 0; k < 8; k++) r[k*27 +: 27] = cfa(k);
    return r;
  endfunction
  function automatic logic [8*18-1:0] pack_b();
    logic [8*18-1:0] r;
    for (int k = 0; k < 8; k++) r[k*18 +: 18] = cfb(k);
    return r;
  endfunction
  localparam logic [8*27-1:0] CA = pack_a();
  localparam logic [8*18-1:0] CB = pack_b();

  logic [2:0] ce;
  logic [1:0] clr;
  logic [26:0] a_x, a_y, s_in;
  logic [25:0] a_z;
  logic [17:0] b_x, b_z;
  logic [18:0] b_y;
  logic [2:0] sel_a, sel_b;
  logic op_sub, op_neg, op_acc, op_rnd;
  logic [63:0] casc_in;
  logic [26:0] so_i, so_c;
  logic [63:0] co_i, co_c, res_i, res_c;

  dmac_slice #(.PRE_A(1'b1), .PRE_B(1'b1), .COEF_A_EN(1'b0), .COEF_B_EN(1'b0),
               .SCAN_SEL(1'b0)) dut_i (
    .clk(clk), .ce(ce), .clr(clr), .a_x(a_x), .a_y(a_y), .a_z(a_z),
    .b_x(b_x), .b_y(b_y), .b_z(b_z), .sel_a(sel_a), .sel_b(sel_b),
    .op_sub(op_sub), .op_neg(op_neg), .op_acc(op_acc), .op_rnd(op_rnd),
    .scan_in(s_in), .scan_out(so_i), .casc_in(casc_in), .casc_out(co_i),
    .result(res_i));

  dmac_slice #(.PRE_A(1'b0), .PRE_B(1'b0), .COEF_A_EN(1'b1), .COEF_B_EN(1'b1),
               .SCAN_SEL(1'b1), .COEF_A(CA), .COEF_B(CB)) dut_c (
    .clk(clk), .ce(ce), .clr(clr), .a_x(a_x), .a_y(a_y), .a_z(a_z),
    .b_x(b_x), .b_y(b_y), .b_z(b_z), .sel_a(sel_a), .sel_b(sel_b),
    .op_sub(op_sub), .op_neg(op_neg), .op_acc(op_acc), .op_rnd(op_rnd),
    .scan_in(so_i), .scan_out(so_c), .casc_in(casc_in), .casc_out(co_c),
    .result(res_c));

  typedef struct { longint ei; longint ec; string tag; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  bit drv_valid = 1'b0;
  bit [2:0] vsh = '0;
  longint prev_i = 0, prev_c = 0, cd1 = 0, cd2 = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint fin(longint pa, longint pb, bit sub, bit neg, bit acc,
                                 bit rnd, longint c, longint prev);
    longint s, b, t;
    s = sub ? pb - pa : pa + pb;
    b = c + (acc ? prev : 0);
    t = neg ? b - s : b + s;
    if (rnd) t += longint'(1) << 17;
    return t;
  endfunction

  task automatic push(input logic [26:0] ax, ay, input logic [25:0] az,
                      input logic [17:0] bx, input logic [18:0] by, input logic [17:0] bz,
                      input logic [2:0] sa, sb, input bit sub, neg, acc, rnd,
                      input longint c, input string tag);
    exp_t e;
    longint pai, pbi, pac, pbc;
    @(negedge clk);
    a_x = ax; a_y = ay; a_z = az; b_x = bx; b_y = by; b_z = bz;
    sel_a = sa; sel_b = sb; op_sub = sub; op_neg = neg; op_acc = acc; op_rnd = rnd;
    casc_in = cd2; cd2 = cd1; cd1 = c;
    drv_valid = 1'b1;
    pai = longint'($signed(ax)) * (longint'($signed(ay)) + longint'($signed(az)));
    pbi = longint'($signed(bx)) * (longint'($signed(by)) + longint'($signed(bz)));
    pac = longint'(cfa(int'(sa))) * longint'($signed(ay));
    pbc = longint'(cfb(int'(sb))) * longint'($signed(by));
    e.ei = fin(pai, pbi, sub, neg, acc, rnd, c, prev_i);
    e.ec = fin(pac, pbc, sub, neg, acc, rnd, c, prev_c);
    e.tag = tag;
    prev_i = e.ei; prev_c = e.ec;
    q.push_back(e);
  endtask

  task automatic rpush(input bit sub, neg, acc, rnd, input string tag);
    push(27'($urandom), 27'($urandom), 26'($urandom), 18'($urandom), 19'($urandom),
         18'($urandom), 3'($urandom), 3'($urandom), sub, neg, acc, rnd,
         {32'($urandom), 32'($urandom)}, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      drv_valid = 1'b0; op_acc = 1'b0;
      casc_in = cd2; cd2 = cd1; cd1 = 0;
    end
  endtask

  // monitor: compares results as items leave the output stage
  always @(posedge clk) begin
    #1;
    vsh = {vsh[1:0], drv_valid};
    if (vsh[2]) begin
      if (q.size() == 0) chk(1'b0, "R1 empty scoreboard", 0, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(res_i == e.ei, {e.tag, " pre-add slice"}, res_i, e.ei);
        chk(res_c == e.ec, {e.tag, " coefficient slice"}, res_c, e.ec);
        chk(co_i == res_i && co_c == res_c, "R8 chain output", co_i, res_i);
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1 watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    logic [63:0] r0;
    logic [26:0] s0;
    ce = 3'b000; clr = 2'b11;
    a_x = '0; a_y = '0; a_z = '0; b_x = '0; b_y = '0; b_z = '0;
    sel_a = '0; sel_b = '0; op_sub = 0; op_neg = 0; op_acc = 0; op_rnd = 0;
    s_in = '0; casc_in = '0;
    repeat (3) @(negedge clk);
    chk(res_i == 0 && co_i == 0, "R11 reset result", res_i, 0);
    chk(so_i == 0 && so_c == 0, "R11 reset scan", 64'(so_i), 0);
    clr = 2'b00; ce = 3'b111;

    for (int i = 0; i < 20; i++) rpush(0, 0, 0, 0, "R1");
    push(27'h3ffffff, 27'h3ffffff, 26'h1ffffff, 18'h1ffff, 19'h3ffff, 18'h1ffff,
         0, 0, 0, 0, 0, 0, 0, "R2 max pre-add");
    push(27'h4000000, 27'h4000000, 26'h2000000, 18'h20000, 19'h40000, 18'h20000,
         1, 2, 0, 0, 0, 0, 0, "R2 min pre-add");
    for (int k = 0; k < 8; k++)
      push(27'($urandom), 27'($urandom), 26'($urandom), 18'($urandom), 19'($urandom),
           18'($urandom), 3'(k), 3'(7 - k), 0, 0, 0, 0, 0, "R3 coefficient sweep");
    for (int i = 0; i < 10; i++) rpush(1, 0, 0, 0, "R4");
    for (int i = 0; i < 10; i++) rpush(0, 1, 0, 0, "R5");
    for (int i = 0; i < 10; i++) rpush(0, 0, 1, 0, "R6");
    push(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 64'd100, "R6 seed");
    for (int i = 0; i < 4; i++) push(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 64'd5, "R6 running sum");
    for (int i = 0; i < 10; i++) rpush(0, 0, 0, 1, "R7");
    push(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R7 constant alone");
    for (int i = 0; i < 200; i++)
      rpush(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R1 mixed");
    idle(3);
    chk(q.size() == 0, "R1 scoreboard drained", q.size(), 0);

    // R10: output stage held while inputs change
    @(negedge clk);
    r0 = res_i; ce = 3'b011;
    a_x = 27'($urandom); a_y = 27'($urandom); b_x = 18'($urandom); op_rnd = 1;
    repeat (3) @(negedge clk);
    chk(res_i == r0, "R10 output hold", res_i, r0);
    // R10: input stage held
    s0 = so_i; ce = 3'b110; a_x = ~so_i;
    @(negedge clk);
    chk(so_i == s0, "R10 input hold", 64'(so_i), 64'(s0));
    // R9: scan path through two slices
    ce = 3'b111; a_x = 27'h5a5a5a5;
    @(negedge clk);
    chk(so_i == 27'h5a5a5a5, "R9 scan first slice", 64'(so_i), 64'h5a5a5a5);
    @(negedge clk);
    chk(so_c == 27'h5a5a5a5, "R9 scan second slice", 64'(so_c), 64'h5a5a5a5);
    // R11: clears override disabled enables
    op_rnd = 1; casc_in = 64'h1234;
    @(negedge clk);
    ce = 3'b000; clr = 2'b10;
    @(negedge clk);
    chk(res_i == 0 && res_c == 0, "R11 pipeline clear", res_i, 0);
    chk(so_i == 27'h5a5a5a5, "R11 input stage kept", 64'(so_i), 64'h5a5a5a5);
    clr = 2'b01;
    @(negedge clk);
    chk(so_i == 0 && so_c == 0, "R11 input clear", 64'(so_i), 0);
    chk(res_i == 0, "R11 result stays cleared", res_i, 0);
    clr = 2'b00;
    finish_run();
  end
endmodule